// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product, after an optional scale step, into two accumulators of a four-entry bank in a single operation. One accumulator is the primary destination and one is the secondary destination. Each source is a 32-bit value. The unit uses either the full word or one 16-bit half of each source, chosen by a select bit for that source.

Commands arrive already decoded. Each command carries the operand values, the size bit, the half-selects, a 2-bit scale code, a fractional-mode bit and two 2-bit accumulator indices. A command is taken on a one-cycle `valid` strobe. One cycle later the accumulators and the status flags are updated and `done` pulses.

The condition flags describe the secondary sum. Each accumulator keeps its own sticky overflow flag. A synchronous `clr` empties the bank and all flags.

Top module: `dual_mac`

## Requirements
- R1: Operand selection. With `size`=1 the full 32-bit `src_a` and `src_b` are used as signed values. With `size`=0 each source gives a signed 16-bit half: its upper half when its select bit (`hi_a`, `hi_b`) is 1, and its lower half when the bit is 0.
- R2: Integer scaling (`frac`=0). Scale code 00 keeps the product unchanged. Code 01 shifts the product left by one. Code 11 shifts it arithmetically right by one. The reserved code 10 behaves like 00.
- R3: Fractional mode (`frac`=1). The product is doubled to align it as a fixed-point value, and the scale code is ignored.
- R4: The low 40 bits of the scaled product, sign-extended to 48 bits, are added to the primary accumulator `sel_p` and to the secondary accumulator `sel_s`. Index 0 to 3 names accumulator 0 to 3, and accumulator i appears at bits [48*i+47:48*i] of `acc_all`. The sums wrap modulo 2^48. All other accumulators keep their values.
- R5: When `sel_p` equals `sel_s`, that accumulator receives the product added twice. The flags are computed on the final value.
- R6: `flag_n` is bit 47 of the secondary result. `flag_z` is 1 exactly when the secondary result is zero.
- R7: `flag_v` is 1 when any of these holds: the product overflows, the secondary accumulation overflows, or the secondary accumulator's sticky flag was already set before the command. Otherwise it is 0.
- R8: A product overflow occurs when the scaled product lies outside the signed 40-bit range. An accumulation overflow occurs when an exact sum lies outside the signed 48-bit range. Sticky flag `pav[i]` is set when such an overflow affects accumulator i. It stays set until a clear.
- R9: `flag_ev` is 1 when the exact secondary sum lies outside the signed 32-bit range in integer mode, or outside the signed 40-bit range in fractional mode. Otherwise it is 0.
- R10: `done` is high for exactly the one cycle after a `valid` cycle. Without `valid`, the accumulators and flags hold their values.
- R11: `rst` or `clr` sets all accumulators, `pav`, the four flags and `done` to zero at the next clock edge. Either one overrides `valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of the bank and flags |
| valid | input | 1 | Command strobe |
| frac | input | 1 | 1 = fractional operands, 0 = integer |
| size | input | 1 | 1 = 32-bit operands, 0 = 16-bit halves |
| hi_a | input | 1 | Half select for src_a (1 = upper) |
| hi_b | input | 1 | Half select for src_b (1 = upper) |
| scale | input | 2 | Scale code |
| sel_p | input | 2 | Primary accumulator index |
| sel_s | input | 2 | Secondary accumulator index |
| src_a | input | 32 | First source value |
| src_b | input | 32 | Second source value |
| acc_all | output | 192 | The four accumulators, accumulator 0 in the low bits |
| pav | output | 4 | Sticky overflow flag per accumulator |
| flag_n | output | 1 | Secondary result negative |
| flag_z | output | 1 | Secondary result zero |
| flag_v | output | 1 | Overflow indication |
| flag_ev | output | 1 | Extension overflow |
| done | output | 1 | Completion pulse |

## Verification
The assertions check these properties on every cycle:
- `done` follows each strobe.
- A clear empties the bank.
- The sticky flags never drop without a clear.
- Accumulators that a command does not name, and the whole bank when idle, keep their values.
- A sticky flag already set on the secondary accumulator forces `flag_v`.

Only the bench's scenarios can show the arithmetic. This covers operand and half selection, the scale codes and the fractional doubling, the double add when both indices match, and the exact thresholds for the 40-bit, 48-bit and extension overflows. The bench compares these against its own wide-integer model over a sweep of every command field combination, and over a long run that drives one accumulator past its 48-bit range.

// File: rtl/dual_mac.sv
module dual_mac #(
  parameter int DW     = 32,
  parameter int PROD_W = 40,
  parameter int ACC_W  = 48,
  parameter int INT_W  = 32,
  parameter int NACC   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  valid,
  input  logic                  frac,
  input  logic                  size,
  input  logic                  hi_a,
  input  logic                  hi_b,
  input  logic [1:0]            scale,
  input  logic [1:0]            sel_p,
  input  logic [1:0]            sel_s,
  input  logic [DW-1:0]         src_a,
  input  logic [DW-1:0]         src_b,
  output logic [NACC*ACC_W-1:0] acc_all,
  output logic [NACC-1:0]       pav,
  output logic                  flag_n,
  output logic                  flag_z,
  output logic                  flag_v,
  output logic                  flag_ev,
  output logic                  done
);
  localparam int HW = DW / 2;
  localparam int PW = 2 * DW + 2;

  logic [ACC_W-1:0] acc [NACC];

  logic signed [DW:0]   ea, eb;
  logic signed [PW-1:0] prod, scaled;
  logic                 pov;
  logic [ACC_W-1:0]     p_ext, base_s, sum1w, sum2w;
  logic [ACC_W:0]       sum1, sum2;
  logic                 ov1, ov2, same, ev_int, ev_frac;
  logic [NACC-1:0]      set_p, set_s;

  assign ea = size ? {src_a[DW-1], src_a}
            : (hi_a ? {{(HW+1){src_a[DW-1]}}, src_a[DW-1:HW]} : {{(HW+1){src_a[HW-1]}}, src_a[HW-1:0]});
  assign eb = size ? {src_b[DW-1], src_b}
            : (hi_b ? {{(HW+1){src_b[DW-1]}}, src_b[DW-1:HW]} : {{(HW+1){src_b[HW-1]}}, src_b[HW-1:0]});

  assign prod = PW'(ea) * PW'(eb);

  always_comb begin
    if (frac) scaled = prod <<< 1;
    else begin
      case (scale)
        2'b01:   scaled = prod <<< 1;
        2'b11:   scaled = prod >>> 1;
        default: scaled = prod;
      endcase
    end
  end

  assign pov   = !((&scaled[PW-1:PROD_W-1]) || !(|scaled[PW-1:PROD_W-1]));
  assign p_ext = {{(ACC_W-PROD_W){scaled[PROD_W-1]}}, scaled[PROD_W-1:0]};

  assign same   = (sel_p == sel_s);
  assign sum1   = {acc[sel_p][ACC_W-1], acc[sel_p]} + {p_ext[ACC_W-1], p_ext};
  assign sum1w  = sum1[ACC_W-1:0];
  assign ov1    = sum1[ACC_W] ^ sum1[ACC_W-1];
  assign base_s = same ? sum1w : acc[sel_s];
  assign sum2   = {base_s[ACC_W-1], base_s} + {p_ext[ACC_W-1], p_ext};
  assign sum2w  = sum2[ACC_W-1:0];
  assign ov2    = (sum2[ACC_W] ^ sum2[ACC_W-1]) || (same && ov1);

  assign ev_int  = !((&sum2[ACC_W:INT_W-1]) || !(|sum2[ACC_W:INT_W-1]));
  assign ev_frac = !((&sum2[ACC_W:PROD_W-1]) || !(|sum2[ACC_W:PROD_W-1]));

  assign set_p = (pov || ov1) ? (NACC'(1) << sel_p) : '0;
  assign set_s = (pov || ov2) ? (NACC'(1) << sel_s) : '0;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NACC; i++) acc[i] <= '0;
      pav     <= '0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
      flag_v  <= 1'b0;
      flag_ev <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= valid;
      if (valid) begin
        acc[sel_p] <= sum1w;
        acc[sel_s] <= sum2w;
        pav        <= pav | set_p | set_s;
        flag_n     <= sum2w[ACC_W-1];
        flag_z     <= (sum2w == '0);
        flag_v     <= pov || ov2 || pav[sel_s];
        flag_ev    <= frac ? ev_frac : ev_int;
      end
    end
  end

  for (genvar g = 0; g < NACC; g++) begin : g_out
    assign acc_all[g*ACC_W +: ACC_W] = acc[g];

    AST_UNNAMED_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!clr && !(valid && (sel_p == g || sel_s == g))) |=> $stable(acc_all[g*ACC_W +: ACC_W])); // R4
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (valid && !clr) |=> done); // R10
  AST_DONE_ONLY_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !done); // R10
  AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!valid && !clr) |=> $stable({flag_n, flag_z, flag_v, flag_ev, pav})); // R10
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_all == '0 && pav == '0 && !done)); // R11
  AST_STICKY_KEPT: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((pav & $past(pav)) == $past(pav))); // R8
  AST_V_FROM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (valid && !clr && pav[sel_s]) |=> flag_v); // R7
endmodule

// File: tb/dual_mac_test.sv
module dual_mac_test;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst, clr, valid, frac, size, hi_a, hi_b;
  logic [1:0] scale, sel_p, sel_s;
  logic [31:0] src_a, src_b;
  logic [191:0] acc_all;
  logic [3:0] pav;
  logic flag_n, flag_z, flag_v, flag_ev, done;

  dual_mac uut (.clk(clk), .rst(rst), .clr(clr), .valid(valid), .frac(frac), .size(size),
    .hi_a(hi_a), .hi_b(hi_b), .scale(scale), .sel_p(sel_p), .sel_s(sel_s),
    .src_a(src_a), .src_b(src_b), .acc_all(acc_all), .pav(pav), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_ev(flag_ev), .done(done));

  int total = 0, bad = 0;
  logic [47:0] ma [4];
  logic [3:0] mpav;
  logic mn, mz, mv, mev;

  localparam logic signed [127:0] L31 = 128'sd1 <<< 31;
  localparam logic signed [127:0] L39 = 128'sd1 <<< 39;
  localparam logic signed [127:0] L47 = 128'sd1 <<< 47;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic out_of(input logic signed [127:0] v, input logic signed [127:0] lim);
    return (v >= lim) || (v < -lim);
  endfunction

  task automatic model(input logic f, input logic sz, input logic ha, input logic hb,
                       input logic [1:0] sc, input logic [1:0] x, input logic [1:0] w,
                       input logic [31:0] a, input logic [31:0] b);
    logic signed [127:0] va, vb, pr, p48, s1, base, s2;
    logic pov, ov1, ov2, same;
    logic [47:0] s1w, s2w;
    va = sz ? 128'($signed(a)) : (ha ? 128'($signed(a[31:16])) : 128'($signed(a[15:0])));
    vb = sz ? 128'($signed(b)) : (hb ? 128'($signed(b[31:16])) : 128'($signed(b[15:0])));
    pr = va * vb;
    if (f) pr = pr * 2;
    else if (sc == 2'b01) pr = pr * 2;
    else if (sc == 2'b11) pr = pr >>> 1;
    pov = out_of(pr, L39);
    p48 = 128'($signed(pr[39:0]));
    same = (x == w);
    s1 = 128'($signed(ma[x])) + p48;
    ov1 = out_of(s1, L47);
    s1w = s1[47:0];
    base = same ? 128'($signed(s1w)) : 128'($signed(ma[w]));
    s2 = base + p48;
    ov2 = out_of(s2, L47) || (same && ov1);
    s2w = s2[47:0];
    mv = pov || ov2 || mpav[w];
    mn = s2w[47];
    mz = (s2w == 0);
    mev = f ? out_of(s2, L39) : out_of(s2, L31);
    if (pov || ov1) mpav[x] = 1'b1;
    if (pov || ov2) mpav[w] = 1'b1;
    ma[x] = s1w;
    ma[w] = s2w;
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 4; i++) chk({tag, " R4 acc"}, 64'(acc_all[i*48 +: 48]), 64'(ma[i]));
    chk({tag, " R8 pav"}, 64'(pav), 64'(mpav));
    chk({tag, " R6/R7/R9 flags"}, 64'({flag_n, flag_z, flag_v, flag_ev}), 64'({mn, mz, mv, mev}));
  endtask

  task automatic op(input string tag, input logic f, input logic sz, input logic ha, input logic hb,
                    input logic [1:0] sc, input logic [1:0] x, input logic [1:0] w,
                    input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    valid = 1; frac = f; size = sz; hi_a = ha; hi_b = hb; scale = sc;
    sel_p = x; sel_s = w; src_a = a; src_b = b;
    model(f, sz, ha, hb, sc, x, w, a, b);
    @(negedge clk);
    valid = 0;
    chk({tag, " R10 done"}, 64'(done), 64'd1);
    check_all(tag);
  endtask

  task automatic clear_bank();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    for (int i = 0; i < 4; i++) ma[i] = '0;
    mpav = '0; mn = 0; mz = 0; mv = 0; mev = 0;
  endtask

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; clr = 0; valid = 0; frac = 0; size = 0; hi_a = 0; hi_b = 0;
    scale = 0; sel_p = 0; sel_s = 0; src_a = 0; src_b = 0;
    for (int i = 0; i < 4; i++) ma[i] = '0;
    mpav = '0; mn = 0; mz = 0; mv = 0; mev = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 reset done", 64'(done), 64'd0);
    check_all("R11 reset");

    // R1 halves: upper of a = -2, lower of b = 3
    op("R1 halves", 0, 0, 1, 0, 2'b00, 0, 1, 32'hFFFE_0005, 32'h0007_0003);
    chk("R1 half product", 64'(acc_all[47:0]), 64'(48'hFFFF_FFFF_FFFA));
    // R2 right shift and reserved code
    op("R2 shr", 0, 1, 0, 0, 2'b11, 2, 3, 32'hFFFF_FFF9, 32'd1);
    op("R2 reserved", 0, 1, 0, 0, 2'b10, 2, 3, 32'd5, 32'd6);
    // R3 fractional ignores scale
    op("R3 frac", 1, 0, 0, 1, 2'b11, 1, 0, 32'h0000_4000, 32'h4000_0000);
    // R5 same index added twice
    clear_bank();
    op("R5 same", 0, 1, 0, 0, 2'b00, 3, 3, 32'd10, 32'd7);
    chk("R5 double add", 64'(acc_all[3*48 +: 48]), 64'd140);
    // R6 zero result
    op("R6 zero", 0, 1, 0, 0, 2'b00, 3, 3, 32'hFFFF_FFF6, 32'd7);
    chk("R6 z set", 64'(flag_z), 64'd1);
    // R9 extension overflow in integer mode
    op("R9 ev", 0, 1, 0, 0, 2'b01, 0, 2, 32'h0001_0000, 32'h0000_8000);
    chk("R9 ev set", 64'(flag_ev), 64'd1);
    // R8 product overflow
    op("R8 pov", 0, 1, 0, 0, 2'b00, 1, 2, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    chk("R7 v on pov", 64'(flag_v), 64'd1);

    // R10 idle cycles leave everything unchanged
    repeat (4) @(negedge clk);
    chk("R10 idle done", 64'(done), 64'd0);
    check_all("R10 idle");

    // R8 accumulation overflow at 48 bits
    clear_bank();
    for (int k = 0; k < 300; k++)
      op("R8 accum", 0, 1, 0, 0, 2'b01, 0, 1, 32'h0008_0000, 32'h0007_FFFF);
    chk("R8 acc overflow sticky", 64'(pav[1:0]), 64'd3);

    // R11 clear mid-stream
    clear_bank();
    check_all("R11 clear");

    // sweep every command field combination
    for (int f = 0; f < 2; f++)
      for (int sz = 0; sz < 2; sz++)
        for (int h = 0; h < 4; h++)
          for (int sc = 0; sc < 4; sc++)
            for (int x = 0; x < 4; x++)
              for (int w = 0; w < 4; w++) begin
                logic [31:0] a, b;
                a = $urandom; b = $urandom;
                if ((x + w) % 3 == 0) begin a = a >> 12; b = b >> 14; end
                op("R1/R2/R3/R4/R5 sweep", f[0], sz[0], h[1], h[0], 2'(sc), 2'(x), 2'(w), a, b);
                if ((w & 3) == 3 && x == 0) clear_bank();
              end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule